// File: doc/BRIEF.md
# Paravirtual Device BAR Region Decoder

This block sits behind one memory BAR of a paravirtual device and steers each host access to one of four fixed windows. The common-configuration window (offsets 0x0000-0x0FFF) and the device-specific window (0x2000-0x2FFF) are not held here. Accesses to them are passed on, each on its own downstream port, with the 12-bit window offset, the byte count and the write data. The interrupt-status window (0x1000-0x1FFF) holds a read-to-clear status register that drives a legacy interrupt line. The notify window starts at 0x3000 and is split into per-queue doorbells, each 0x10000 bytes wide. A write there produces a one-cycle notify pulse that carries the queue index.

An access is 1 to 4 bytes wide and little-endian. Byte lane 0 of the data bus (bits 7:0) carries the addressed byte. Requests arrive on a valid/ready channel. Only one access is in flight at a time: `req_ready` is high only when no earlier access is waiting for its response. The response is offered on `rsp_valid` and holds its data until `rsp_ready` is seen high at a clock edge. The block therefore applies back-pressure through `req_ready`. Each downstream port holds its request until its ready is high. The target returns exactly one `*_rvalid` cycle, no earlier than the cycle after that handshake, and this applies to writes too.

Top module: `vbar_decode`

## Requirements
- R1: A request with an address below 0x1000 goes out on the cm_ port. A request at 0x2000-0x2FFF goes out on the dv_ port. The forwarded offset is address bits 11:0, and the forwarded write flag and write data are the request's own. At most one port is valid at a time.
- R2: Sizes 1, 2, 3 and 4 are forwarded on the common port. Only sizes 1, 2 and 4 are forwarded on the device port. Any other size on either window is not forwarded and reads 0.
- R3: A forwarded read returns the target's data masked to its low size bytes (size 1 keeps bits 7:0, size 2 keeps 15:0, size 3 keeps 23:0, size 4 keeps 31:0). A write response returns 0.
- R4: A read of size 1-4 at 0x1000 returns the status register in bits 7:0 and clears the register. The interrupt line is low in the cycle after the access is accepted, unless a set-strobe arrives.
- R5: Each set-strobe bit ORs into the status register. The interrupt line is high in the cycle after any strobe bit is set, and it stays high while any status bit is set.
- R6: When a set-strobe arrives in the same cycle as a clearing read, the read returns the old value and the newly set bits survive the clear.
- R7: Writes in the status window leave the status register and the interrupt line unchanged.
- R8: A write of size 1-4 at address A in the range 0x3000 to 0x3000 + QMAX*0x10000 - 1 gives `ntf_pulse` high for exactly the one cycle after acceptance, with `ntf_qid` = (A - 0x3000) / 0x10000.
- R9: Reads in the notify window return 0 and give no pulse.
- R10: An address above the notify window, a status-window offset other than 0, or a size of 0 or more than 4 to the status or notify window reads 0. On a write it changes nothing and forwards nothing.
- R11: `req_ready` is low while a response is pending. `rsp_valid` and `rsp_rdata` hold until `rsp_ready` is high. A downstream valid holds with a stable offset until its ready is high.
- R12: After reset the interrupt line, the status register, `ntf_pulse`, `rsp_valid` and both downstream valids are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | BAR byte offset (19 bits by default) |
| req_size | input | 3 | Access byte count |
| req_wdata | input | 32 | Write data, lane 0 = addressed byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| cm_valid | output | 1 | Common-window request valid |
| cm_ready | input | 1 | Common target ready |
| cm_write | output | 1 | Common request is a write |
| cm_off | output | 12 | Offset in common window |
| cm_size | output | 3 | Byte count |
| cm_wdata | output | 32 | Write data |
| cm_rvalid | input | 1 | Common target completion |
| cm_rdata | input | 32 | Common target read data |
| dv_valid | output | 1 | Device-window request valid |
| dv_ready | input | 1 | Device target ready |
| dv_write | output | 1 | Device request is a write |
| dv_off | output | 12 | Offset in device window |
| dv_size | output | 3 | Byte count |
| dv_wdata | output | 32 | Write data |
| dv_rvalid | input | 1 | Device target completion |
| dv_rdata | input | 32 | Device target read data |
| isr_set | input | ISR_W | Status set-strobes, one cycle each |
| irq_o | output | 1 | Legacy interrupt line |
| ntf_pulse | output | 1 | One-cycle queue notify |
| ntf_qid | output | QID_W | Notified queue index |

## Verification
The bench first goes after the read-clear race. If a design let the clear win over a strobe in the same cycle, it would lose an interrupt: the follow-up read would return 0 and the line would drop. Size filtering on the device window is tried with sizes 3 and 5. A decoder that forwarded them would show an unexpected handshake on the device port, and one that returned stale data would read non-zero. Doorbell addresses cover the first queue, a non-zero offset inside the last queue, a read, a size-0 write and addresses just past the window. A wrong divisor or a missing bound check would show up as a bad `ntf_qid` or a stray pulse. Response back-pressure and the alternating device ready would catch a design that dropped data or accepted a second request early.

// File: rtl/vbar_pkg.sv
package vbar_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 12;

  typedef enum logic [2:0] {
    RG_COMMON,
    RG_ISR,
    RG_DEVICE,
    RG_NOTIFY,
    RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWD,
    ST_WAIT,
    ST_RSP
  } state_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      3'd3:    lane_mask = 32'h00FF_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/vbar_region_dec.sv
module vbar_region_dec
  import vbar_pkg::*;
#(
  parameter int QMAX       = 4,
  parameter int STRIDE_LG2 = 16,
  parameter int ADDR_W     = 19,
  parameter int QID_W      = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [QID_W-1:0]  qid_o,
  output logic              qok_o,
  output logic              size_ok_o,
  output logic              dev_size_ok_o
);
  localparam logic [ADDR_W-1:0] ISR_BASE = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] DEV_BASE = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] NTF_BASE = ADDR_W'(32'h3000);
  localparam logic [ADDR_W-1:0] NTF_END  = ADDR_W'(32'h3000 + (QMAX << STRIDE_LG2));

  logic [ADDR_W-1:0] ntf_off;
  logic [ADDR_W-1:0] q_full;

  always_comb begin
    ntf_off = addr_i - NTF_BASE;
    q_full  = ntf_off >> STRIDE_LG2;
    qok_o   = (q_full < ADDR_W'(QMAX));
    qid_o   = q_full[QID_W-1:0];
    off_o   = addr_i[OFF_W-1:0];

    if (addr_i < ISR_BASE)      region_o = RG_COMMON;
    else if (addr_i < DEV_BASE) region_o = RG_ISR;
    else if (addr_i < NTF_BASE) region_o = RG_DEVICE;
    else if (addr_i < NTF_END)  region_o = RG_NOTIFY;
    else                        region_o = RG_NONE;

    size_ok_o     = (size_i != 3'd0) && (size_i <= 3'd4);
    dev_size_ok_o = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  end
endmodule

// File: rtl/vbar_isr.sv
module vbar_isr #(
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ISR_W-1:0] set_i,
  input  logic             clr_i,
  output logic [ISR_W-1:0] val_o,
  output logic             irq_o
);
  logic [ISR_W-1:0] nxt;

  always_comb nxt = (clr_i ? '0 : val_o) | set_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_o <= '0;
      irq_o <= 1'b0;
    end else begin
      val_o <= nxt;
      irq_o <= |nxt;
    end
  end
endmodule

// File: rtl/vbar_notify.sv
module vbar_notify #(
  parameter int QID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [QID_W-1:0] qid_i,
  output logic             pulse_o,
  output logic [QID_W-1:0] qid_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      qid_o   <= '0;
    end else begin
      pulse_o <= fire_i;
      if (fire_i) qid_o <= qid_i;
    end
  end
endmodule

// File: rtl/vbar_decode.sv
module vbar_decode
  import vbar_pkg::*;
#(
  parameter int QMAX       = 4,
  parameter int STRIDE_LG2 = 16,
  parameter int ISR_W      = 8,
  localparam int ADDR_W    = $clog2(2 * QMAX * (1 << STRIDE_LG2)),
  localparam int QID_W     = (QMAX > 1) ? $clog2(QMAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              cm_valid,
  input  logic              cm_ready,
  output logic              cm_write,
  output logic [11:0]       cm_off,
  output logic [2:0]        cm_size,
  output logic [31:0]       cm_wdata,
  input  logic              cm_rvalid,
  input  logic [31:0]       cm_rdata,
  output logic              dv_valid,
  input  logic              dv_ready,
  output logic              dv_write,
  output logic [11:0]       dv_off,
  output logic [2:0]        dv_size,
  output logic [31:0]       dv_wdata,
  input  logic              dv_rvalid,
  input  logic [31:0]       dv_rdata,
  input  logic [ISR_W-1:0]  isr_set,
  output logic              irq_o,
  output logic              ntf_pulse,
  output logic [QID_W-1:0]  ntf_qid
);
  state_e           st;
  logic             tgt;
  logic             l_write;
  logic [OFF_W-1:0] l_off;
  logic [2:0]       l_size;
  logic [31:0]      l_wdata;
  logic [31:0]      rdata_q;

  region_e          rg;
  logic [OFF_W-1:0] d_off;
  logic [QID_W-1:0] d_qid;
  logic             d_qok, d_sok, d_dsok;

  logic             acc, fwd_cm, fwd_dv, isr_hit, isr_clr, ntf_fire;
  logic [ISR_W-1:0] isr_val;
  logic [1:0]       f_ready, f_rvalid;
  logic [31:0]      f_rdata [2];
  logic [31:0]      local_rd;

  vbar_region_dec #(
    .QMAX(QMAX), .STRIDE_LG2(STRIDE_LG2), .ADDR_W(ADDR_W), .QID_W(QID_W)
  ) u_dec (
    .addr_i(req_addr), .size_i(req_size), .region_o(rg), .off_o(d_off),
    .qid_o(d_qid), .qok_o(d_qok), .size_ok_o(d_sok), .dev_size_ok_o(d_dsok)
  );

  vbar_isr #(.ISR_W(ISR_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_i(isr_set), .clr_i(isr_clr),
    .val_o(isr_val), .irq_o(irq_o)
  );

  vbar_notify #(.QID_W(QID_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .fire_i(ntf_fire), .qid_i(d_qid),
    .pulse_o(ntf_pulse), .qid_o(ntf_qid)
  );

  assign f_ready    = {dv_ready, cm_ready};
  assign f_rvalid   = {dv_rvalid, cm_rvalid};
  assign f_rdata[0] = cm_rdata;
  assign f_rdata[1] = dv_rdata;

  always_comb begin
    req_ready = (st == ST_IDLE);
    acc       = req_valid && req_ready;
    fwd_cm    = (rg == RG_COMMON) && d_sok;
    fwd_dv    = (rg == RG_DEVICE) && d_dsok;
    isr_hit   = (rg == RG_ISR) && (d_off == '0) && d_sok;
    isr_clr   = acc && !req_write && isr_hit;
    ntf_fire  = acc && req_write && (rg == RG_NOTIFY) && d_qok && d_sok;
    local_rd  = isr_clr ? 32'(isr_val) : 32'h0;
  end

  always_comb begin
    cm_valid  = (st == ST_FWD) && !tgt;
    dv_valid  = (st == ST_FWD) && tgt;
    cm_write  = l_write;
    dv_write  = l_write;
    cm_off    = l_off;
    dv_off    = l_off;
    cm_size   = l_size;
    dv_size   = l_size;
    cm_wdata  = l_wdata;
    dv_wdata  = l_wdata;
    rsp_valid = (st == ST_RSP);
    rsp_rdata = rdata_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tgt     <= 1'b0;
      l_write <= 1'b0;
      l_off   <= '0;
      l_size  <= '0;
      l_wdata <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          l_write <= req_write;
          l_off   <= d_off;
          l_size  <= req_size;
          l_wdata <= req_wdata;
          if (fwd_cm || fwd_dv) begin
            tgt <= fwd_dv;
            st  <= ST_FWD;
          end else begin
            rdata_q <= local_rd;
            st      <= ST_RSP;
          end
        end
        ST_FWD:  if (f_ready[tgt]) st <= ST_WAIT;
        ST_WAIT: if (f_rvalid[tgt]) begin
          rdata_q <= l_write ? 32'h0 : (f_rdata[tgt] & lane_mask(l_size));
          st      <= ST_RSP;
        end
        default: if (rsp_ready) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vbar_decode_chk.sv
module vbar_decode_chk #(
  parameter int ADDR_W = 19,
  parameter int ISR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic [11:0]       cm_off,
  input logic              dv_valid,
  input logic              dv_ready,
  input logic [11:0]       dv_off,
  input logic [ISR_W-1:0]  isr_set,
  input logic              irq_o,
  input logic              ntf_pulse
);
  logic isr_rd_acc, isr_wr_acc;
  assign isr_rd_acc = req_valid && req_ready && !req_write && (req_addr == ADDR_W'(32'h1000))
                      && (req_size != 3'd0) && (req_size <= 3'd4);
  assign isr_wr_acc = req_valid && req_ready && req_write && (req_addr == ADDR_W'(32'h1000));

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && dv_valid)); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
  AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_off)); // R11
  AST_DV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && !dv_ready |=> dv_valid && $stable(dv_off)); // R11
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set != '0) |=> irq_o); // R5
  AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd_acc && (isr_set == '0) |=> !irq_o); // R4
  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_wr_acc && (isr_set == '0) |=> irq_o == $past(irq_o)); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_pulse |=> !ntf_pulse); // R8
endmodule

bind vbar_decode vbar_decode_chk #(.ADDR_W(ADDR_W), .ISR_W(ISR_W)) chk_i (.*);

// File: tb/vbar_decode_tb.sv
module vbar_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [18:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cm_valid, cm_write, dv_valid, dv_write;
  logic        cm_ready = 1, dv_ready = 0, cm_rvalid = 0, dv_rvalid = 0;
  logic [31:0] cm_rdata = '0, dv_rdata = '0, cm_wdata, dv_wdata;
  logic [11:0] cm_off, dv_off;
  logic [2:0]  cm_size, dv_size;
  logic [7:0]  isr_set = '0;
  logic        irq_o, ntf_pulse;
  logic [1:0]  ntf_qid;

  always #5 clk = ~clk;

  vbar_decode dut_i (.*);

  int n_chk = 0, n_err = 0;
  int m_isr = 0, m_qid = 0;
  bit m_ntf = 0;
  string phase_tag = "R4";
  int    eq_rd[$];
  string eq_tag[$];
  int fq_port[$], fq_off[$], fq_size[$], fq_wr[$], fq_wd[$];
  bit hs_cm = 0, hs_dv = 0;
  int hs_cm_off = 0, hs_dv_off = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int region_of(input int a);
    if (a < 'h1000) return 0;
    if (a < 'h2000) return 1;
    if (a < 'h3000) return 2;
    if (a < 'h3000 + 4 * 'h10000) return 3;
    return 4;
  endfunction

  function automatic int mask_of(input int sz);
    if (sz == 1) return 'hFF;
    if (sz == 2) return 'hFFFF;
    if (sz == 3) return 'hFFFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check_fwd(input int port, input logic wr, input logic [11:0] off,
                           input logic [2:0] sz, input logic [31:0] wd);
    if (fq_port.size() == 0) begin
      chk(0, "R2 unexpected forward", 32'(port), 32'hFFFF_FFFF);
    end else begin
      int p, o, s, w, d;
      p = fq_port.pop_front(); o = fq_off.pop_front(); s = fq_size.pop_front();
      w = fq_wr.pop_front(); d = fq_wd.pop_front();
      chk(p == port, "R1 port", 32'(port), 32'(p));
      chk(off == o[11:0], "R1 offset", 32'(off), 32'(o));
      chk(sz == s[2:0], "R2 size", 32'(sz), 32'(s));
      chk(wr == w[0], "R1 write flag", 32'(wr), 32'(w));
      if (wr) chk(wd == d, "R1 wdata", wd, d);
    end
  endtask

  // Reference model and monitors, evaluated away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int a, sz, rg, nxt;
      bit acc, clr, fire, sok;
      chk(irq_o == (m_isr != 0), "R5/R6 irq line", 32'(irq_o), 32'(m_isr != 0));
      chk(ntf_pulse == m_ntf, "R8 pulse", 32'(ntf_pulse), 32'(m_ntf));
      if (m_ntf) chk(ntf_qid == m_qid[1:0], "R8 qid", 32'(ntf_qid), 32'(m_qid));
      if (rsp_valid && rsp_ready) begin
        if (eq_rd.size() == 0) chk(0, "R11 stray response", rsp_rdata, 0);
        else begin
          int e; string t;
          e = eq_rd.pop_front(); t = eq_tag.pop_front();
          chk(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
      if (cm_valid && cm_ready) begin
        check_fwd(0, cm_write, cm_off, cm_size, cm_wdata);
        hs_cm = 1; hs_cm_off = int'(cm_off);
      end
      if (dv_valid && dv_ready) begin
        check_fwd(1, dv_write, dv_off, dv_size, dv_wdata);
        hs_dv = 1; hs_dv_off = int'(dv_off);
      end
      acc = req_valid && req_ready;
      clr = 0; fire = 0; nxt = 0;
      if (acc) begin
        a = int'(req_addr); sz = int'(req_size); rg = region_of(a);
        sok = (sz >= 1) && (sz <= 4);
        if ((rg == 0 && sok) || (rg == 2 && (sz == 1 || sz == 2 || sz == 4))) begin
          fq_port.push_back(rg == 0 ? 0 : 1); fq_off.push_back(a % 'h1000);
          fq_size.push_back(sz); fq_wr.push_back(int'(req_write)); fq_wd.push_back(int'(req_wdata));
          eq_rd.push_back(req_write ? 0 :
            (((rg == 0 ? 32'hC000_0000 : 32'hD000_0000) | (a % 'h1000)) & mask_of(sz)));
          eq_tag.push_back("R3 forwarded data");
        end else if (rg == 1) begin
          if (a == 'h1000 && sok && !req_write) begin
            eq_rd.push_back(m_isr); clr = 1;
          end else eq_rd.push_back(0);
          eq_tag.push_back(phase_tag);
        end else if (rg == 3) begin
          eq_rd.push_back(0);
          eq_tag.push_back(req_write ? "R8 notify write data" : "R9 notify read");
          if (req_write && sok) begin fire = 1; nxt = (a - 'h3000) / 'h10000; end
        end else begin
          eq_rd.push_back(0);
          eq_tag.push_back(rg == 4 ? "R10 unmapped" : "R2 bad size");
        end
      end
      m_isr = (clr ? 0 : m_isr) | int'(isr_set);
      m_ntf = fire;
      if (fire) m_qid = nxt;
    end
  end

  // Downstream responders: one completion the cycle after each handshake
  always @(posedge clk) begin
    #1;
    cm_rvalid = hs_cm; cm_rdata = 32'hC000_0000 | hs_cm_off; hs_cm = 0;
    dv_rvalid = hs_dv; dv_rdata = 32'hD000_0000 | hs_dv_off; hs_dv = 0;
    dv_ready  = ~dv_ready;
  end

  task automatic acc(input bit w, input int a, input int sz, input logic [31:0] wd,
                     input logic [7:0] st, input int hold);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a[18:0]; req_size = sz[2:0];
    req_wdata = wd; isr_set = st; rsp_ready = (hold == 0);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; isr_set = 0;
    if (hold > 0) begin
      do @(negedge clk); while (!rsp_valid);
      for (int i = 0; i < hold; i++) begin
        chk(rsp_valid && !req_ready, "R11 back-pressure hold", 32'({rsp_valid, req_ready}), 32'h2);
        @(negedge clk);
      end
      @(posedge clk); #1 rsp_ready = 1;
    end
    do @(negedge clk); while (!(rsp_valid && rsp_ready));
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(posedge clk); #1 isr_set = v;
    @(posedge clk); #1 isr_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!irq_o && !ntf_pulse && !rsp_valid, "R12 outputs idle", 32'({irq_o, ntf_pulse, rsp_valid}), 0);
    chk(!cm_valid && !dv_valid && req_ready, "R12 ready", 32'({cm_valid, dv_valid, req_ready}), 1);
    // common window
    acc(0, 'h0010, 4, 0, 0, 0);
    acc(0, 'h0FFF, 1, 0, 0, 0);
    acc(1, 'h0400, 2, 32'h1234, 0, 0);
    acc(0, 'h0100, 3, 0, 0, 0);
    acc(0, 'h0020, 0, 0, 0, 0);
    // device window
    acc(0, 'h2008, 4, 0, 0, 0);
    acc(0, 'h2002, 2, 0, 0, 0);
    acc(1, 'h2003, 1, 32'hAB, 0, 0);
    acc(0, 'h2004, 3, 0, 0, 0);
    acc(1, 'h2004, 3, 32'h55, 0, 0);
    acc(0, 'h2000, 5, 0, 0, 0);
    // status register
    phase_tag = "R4 status read";
    pulse_set(8'h05);
    acc(0, 'h1000, 1, 0, 0, 0);
    phase_tag = "R7 status write";
    pulse_set(8'h02);
    acc(1, 'h1000, 4, 0, 0, 0);
    acc(0, 'h1000, 4, 0, 0, 0);
    phase_tag = "R6 set beats clear";
    pulse_set(8'h01);
    acc(0, 'h1000, 2, 0, 8'h80, 0);
    acc(0, 'h1000, 1, 0, 0, 0);
    phase_tag = "R10 status offset";
    pulse_set(8'h10);
    acc(0, 'h1004, 4, 0, 0, 0);
    acc(0, 'h1000, 1, 0, 0, 0);
    // doorbells
    acc(1, 'h3000, 4, 1, 0, 0);
    acc(1, 'h33004, 2, 1, 0, 0);
    acc(1, 'h23000, 1, 1, 0, 0);
    acc(0, 'h13000, 4, 0, 0, 0);
    acc(1, 'h43000, 4, 1, 0, 0);
    acc(1, 'h3000, 0, 1, 0, 0);
    acc(1, 'h7FFFC, 4, 1, 0, 0);
    acc(0, 'h50000, 4, 0, 0, 0);
    // back-pressure
    acc(0, 'h0040, 4, 0, 0, 3);
    acc(1, 'h2010, 4, 32'hCAFE, 0, 2);
    repeat (3) @(negedge clk);
    chk(fq_port.size() == 0, "R2 missing forward", 32'(fq_port.size()), 0);
    chk(eq_rd.size() == 0, "R11 missing response", 32'(eq_rd.size()), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule